// File: doc/BRIEF.md
# Mailbox Deadline Watchdog

This block watches a bank of message mailboxes for missed deadlines. Each mailbox has a deadline word held in a single-port RAM. A scanning engine reads one entry per cycle in ascending order. It compares that entry with a free-running time stamp and sets the mailbox's time-out status bit when three things hold at once: the deadline has been reached, watching is enabled for that mailbox, and the mailbox still has a pending request.

Each mailbox maps, through its own line-select bit, onto one of two global time-out flags. Each flag raises a single-cycle interrupt pulse when it becomes set. A status bit clears itself when its mailbox later reports a successful transfer. Software can also clear status bits by writing ones.

Because the comparison is a sequential scan, a mailbox whose request completes before its slot comes round is never flagged, even when its deadline has already passed. The CPU deadline port is plain and never back-pressured. A write takes the RAM port for that cycle and the scan waits one cycle.

Top module: `mbox_deadline_watch`

## Requirements
- R1: During and right after reset, `to_status`, `to_flag` and `to_irq` are all zero and `ts_value` is 0.
- R2: Bit n of `to_status` is set only by a comparison of entry n in which, all in that cycle, `ts_value` >= deadline n (unsigned), `toc_en[n]` = 1 and `tx_pend[n]` = 1. Once set, it stays set until it is cleared.
- R3: The scan issues RAM address 0, 1, …, 31, 0, … one per cycle. The comparison happens in the cycle after the address is issued, and the status bit is visible one cycle after that.
- R4: A deadline write (`dl_wr` = 1) is written to entry `dl_addr` in that cycle. The scan pointer holds and no comparison is made in the following cycle. Later comparisons use the new value.
- R5: A mailbox whose `tx_pend` bit drops before its entry is compared is not flagged, even if its deadline has passed.
- R6: `done_evt[n]` = 1 clears status bit n at the next edge.
- R7: When `clr_we` = 1, each bit set in `clr_mask` clears the matching status bit at the next edge. If a set and a clear (CPU or `done_evt`) hit the same bit in the same cycle, the set wins.
- R8: `to_flag[0]` is the OR of the status bits whose `lvl_sel` bit is 0, and `to_flag[1]` is the OR of those whose `lvl_sel` bit is 1. Each flag follows the status and `lvl_sel` in the same cycle.
- R9: `to_irq[k]` is high for exactly the one cycle in which `to_flag[k]` goes from 0 to 1. It is not repeated while the flag stays high.
- R10: `ts_value` counts up by one every clock from 0 and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dl_wr | input | 1 | Deadline write strobe |
| dl_addr | input | 5 | Deadline entry index |
| dl_data | input | 32 | Deadline value |
| toc_en | input | 32 | Per-mailbox time-out watch enable |
| tx_pend | input | 32 | Per-mailbox pending request |
| done_evt | input | 32 | Per-mailbox successful transfer event |
| lvl_sel | input | 32 | Per-mailbox flag line select |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 32 | Write-1-to-clear mask |
| ts_value | output | 32 | Time stamp counter |
| to_status | output | 32 | Per-mailbox time-out status |
| to_flag | output | 2 | Global time-out flags |
| to_irq | output | 2 | Interrupt pulses, one per flag |

## Verification
A status bit becomes visible two edges after its entry's address is issued: one edge for the RAM read and one for the status register. Clears from `done_evt` and `clr_mask` take effect at the next edge. Flags and interrupt pulses follow the status in the same cycle.

The bench keeps a behavioural model that is advanced at each rising edge from the inputs held stable since the previous falling edge. It compares every output at the falling edge. A pipeline entry in the model carries the deadline captured at issue time, so stalls from deadline writes shift the expected timing exactly.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  localparam int unsigned MDW_MBOX  = 32;
  localparam int unsigned MDW_TS_W  = 32;
  localparam int unsigned MDW_LINES = 2;
endpackage

// File: rtl/mdw_deadline_ram.sv
module mdw_deadline_ram #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // single port: a write cycle performs no read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else    rdata     <= mem[addr];
  end
endmodule

// File: rtl/mdw_scan_ctrl.sv
module mdw_scan_ctrl #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned TS_W  = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_we,
  output logic [AW-1:0]   scan_ptr,
  output logic            cmp_valid,
  output logic [AW-1:0]   cmp_idx,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_ptr  <= '0;
      cmp_valid <= 1'b0;
      cmp_idx   <= '0;
      ts        <= '0;
    end else begin
      ts <= ts + 1'b1;
      if (cpu_we) begin
        cmp_valid <= 1'b0;
      end else begin
        cmp_valid <= 1'b1;
        cmp_idx   <= scan_ptr;
        scan_ptr  <= (scan_ptr == LAST) ? '0 : scan_ptr + 1'b1;
      end
    end
  end

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> (scan_ptr == $past(scan_ptr)) && !cmp_valid);
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> scan_ptr == (($past(scan_ptr) == LAST) ? '0 : $past(scan_ptr) + 1'b1));
  // R10
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ts == $past(ts) + 1'b1);
endmodule

// File: rtl/mdw_status_bank.sv
module mdw_status_bank #(
  parameter int unsigned N    = 32,
  parameter int unsigned TS_W = 32,
  localparam int unsigned AW  = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_valid,
  input  logic [AW-1:0]   cmp_idx,
  input  logic [TS_W-1:0] deadline,
  input  logic [TS_W-1:0] ts,
  input  logic [N-1:0]    toc_en,
  input  logic [N-1:0]    tx_pend,
  input  logic [N-1:0]    done_evt,
  input  logic            clr_we,
  input  logic [N-1:0]    clr_mask,
  output logic [N-1:0]    status
);
  logic          reached;
  logic [N-1:0]  set_vec;
  logic [N-1:0]  clr_vec;

  assign reached = cmp_valid && (ts >= deadline);
  assign clr_vec = (clr_we ? clr_mask : '0) | done_evt;

  for (genvar n = 0; n < N; n++) begin : g_bit
    assign set_vec[n] = reached && (cmp_idx == AW'(n)) && toc_en[n] && tx_pend[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  // R2
  rise_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status & ~$past(status) & ~($past(toc_en) & $past(tx_pend))) == '0));
  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_evt & ~set_vec)) |=> ((status & $past(done_evt & ~set_vec)) == '0));
  // R7
  cpu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status & $past(clr_mask & ~set_vec)) == '0));
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/mdw_flag_irq.sv
module mdw_flag_irq #(
  parameter int unsigned N     = 32,
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     status,
  input  logic [N-1:0]     lvl_sel,
  output logic [LINES-1:0] flag,
  output logic [LINES-1:0] irq
);
  logic [LINES-1:0] flag_d;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic [N-1:0] member;
    if (k == 0) begin : g_lo
      assign member = ~lvl_sel;
    end else begin : g_hi
      assign member = lvl_sel;
    end
    assign flag[k] = |(status & member);
    assign irq[k]  = flag[k] & ~flag_d[k];

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[k] |=> !irq[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_d <= '0;
    else        flag_d <= flag;
  end

  // R8
  idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> (flag == '0));
endmodule

// File: rtl/mbox_deadline_watch.sv
module mbox_deadline_watch
  import mdw_pkg::*;
#(
  parameter int unsigned N    = MDW_MBOX,
  parameter int unsigned TS_W = MDW_TS_W,
  localparam int unsigned AW  = $clog2(N),
  localparam int unsigned LN  = MDW_LINES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dl_wr,
  input  logic [AW-1:0]   dl_addr,
  input  logic [TS_W-1:0] dl_data,
  input  logic [N-1:0]    toc_en,
  input  logic [N-1:0]    tx_pend,
  input  logic [N-1:0]    done_evt,
  input  logic [N-1:0]    lvl_sel,
  input  logic            clr_we,
  input  logic [N-1:0]    clr_mask,
  output logic [TS_W-1:0] ts_value,
  output logic [N-1:0]    to_status,
  output logic [LN-1:0]   to_flag,
  output logic [LN-1:0]   to_irq
);
  logic [AW-1:0]   scan_ptr;
  logic [AW-1:0]   ram_addr;
  logic [TS_W-1:0] ram_rd;
  logic            cmp_valid;
  logic [AW-1:0]   cmp_idx;

  assign ram_addr = dl_wr ? dl_addr : scan_ptr;

  mdw_scan_ctrl #(.DEPTH(N), .TS_W(TS_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .cpu_we(dl_wr),
    .scan_ptr(scan_ptr), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .ts(ts_value)
  );

  mdw_deadline_ram #(.DEPTH(N), .W(TS_W)) u_ram (
    .clk(clk), .we(dl_wr), .addr(ram_addr), .wdata(dl_data), .rdata(ram_rd)
  );

  mdw_status_bank #(.N(N), .TS_W(TS_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .deadline(ram_rd), .ts(ts_value), .toc_en(toc_en), .tx_pend(tx_pend),
    .done_evt(done_evt), .clr_we(clr_we), .clr_mask(clr_mask), .status(to_status)
  );

  mdw_flag_irq #(.N(N), .LINES(LN)) u_flag (
    .clk(clk), .rst_n(rst_n), .status(to_status), .lvl_sel(lvl_sel),
    .flag(to_flag), .irq(to_irq)
  );
endmodule

// File: tb/mbox_deadline_watch_test.sv
module mbox_deadline_watch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dl_wr = 1'b0;
  logic [4:0]  dl_addr = '0;
  logic [31:0] dl_data = '0;
  logic [31:0] toc_en = '0, tx_pend = '0, done_evt = '0, lvl_sel = '0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_mask = '0;
  logic [31:0] ts_value, to_status;
  logic [1:0]  to_flag, to_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mbox_deadline_watch uut (
    .clk(clk), .rst_n(rst_n), .dl_wr(dl_wr), .dl_addr(dl_addr), .dl_data(dl_data),
    .toc_en(toc_en), .tx_pend(tx_pend), .done_evt(done_evt), .lvl_sel(lvl_sel),
    .clr_we(clr_we), .clr_mask(clr_mask), .ts_value(ts_value), .to_status(to_status),
    .to_flag(to_flag), .to_irq(to_irq)
  );

  // behavioural reference
  logic [31:0] m_ram [32];
  int          m_ptr, m_pi;
  bit          m_pv;
  logic [31:0] m_pd, m_ts, m_stat;
  logic [1:0]  m_fprev;

  function automatic logic [1:0] mflags(input logic [31:0] st);
    logic [1:0] f;
    f[0] = |(st & ~lvl_sel);
    f[1] = |(st & lvl_sel);
    return f;
  endfunction

  initial for (int i = 0; i < 32; i++) m_ram[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_pv = 0; m_pi = 0; m_pd = '0; m_ts = '0; m_stat = '0; m_fprev = '0;
    end else begin
      logic [31:0] setv;
      setv = '0;
      if (m_pv && m_ts >= m_pd && toc_en[m_pi] && tx_pend[m_pi]) setv[m_pi] = 1'b1;
      m_fprev = mflags(m_stat);
      m_stat = (m_stat & ~(clr_we ? clr_mask : 32'h0) & ~done_evt) | setv;
      if (dl_wr) begin
        m_ram[dl_addr] = dl_data;
        m_pv = 0;
      end else begin
        m_pv = 1; m_pi = m_ptr; m_pd = m_ram[m_ptr];
        m_ptr = (m_ptr + 1) % 32;
      end
      m_ts = m_ts + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R3 status timing, R8 flags, R9 pulses, R10 counter: compared every cycle
  task automatic compare_all();
    logic [1:0] ef;
    ef = mflags(m_stat);
    chk(to_status == m_stat, "R3 status", to_status, m_stat);
    chk(to_flag == ef, "R8 flag", 32'(to_flag), 32'(ef));
    chk(to_irq == (ef & ~m_fprev), "R9 irq", 32'(to_irq), 32'(ef & ~m_fprev));
    chk(ts_value == m_ts, "R10 ts", ts_value, m_ts);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    if (rst_n) compare_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    dl_wr = 1'b1; dl_addr = 5'(a); dl_data = d;
    tick();
    dl_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int irq_cnt;
    int seen;
    run(3);
    // R1
    chk(to_status == 0 && to_flag == 0 && to_irq == 0, "R1 reset outputs",
        {to_status[29:0], to_flag}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    chk(ts_value == 0 && to_status == 0, "R1 after release", ts_value, 32'h0);

    for (int i = 0; i < 32; i++) wr(i, 32'hFFFF_FF00);
    wr(5, 32'd60); wr(6, 32'hFFFF_FFF0); wr(7, 32'd20); wr(3, 32'd0);
    lvl_sel = 32'h0000_0020;
    toc_en = 32'h0000_00E0; tx_pend = 32'h0000_0060;
    run(70);
    chk(to_status[5] == 1'b1, "R2 due bit set", 32'(to_status[5]), 32'h1);
    chk(to_status[6] == 1'b0, "R2 not yet due", 32'(to_status[6]), 32'h0);
    chk(to_status[7] == 1'b0, "R2 no pending", 32'(to_status[7]), 32'h0);
    chk(to_flag == 2'b10, "R8 line select", 32'(to_flag), 32'h2);

    // R5: pending for a short window away from slot 7
    while (m_ptr != 10) tick();
    tx_pend[7] = 1'b1; run(5); tx_pend[7] = 1'b0;
    run(40);
    chk(to_status[7] == 1'b0, "R5 completed before scan", 32'(to_status[7]), 32'h0);

    // R6
    done_evt[5] = 1'b1; tx_pend[5] = 1'b0;
    tick();
    done_evt[5] = 1'b0;
    chk(to_status[5] == 1'b0, "R6 success clears", 32'(to_status[5]), 32'h0);
    chk(to_flag[1] == 1'b0, "R6 flag drops", 32'(to_flag[1]), 32'h0);

    // R9 one pulse on line 0
    irq_cnt = 0;
    tx_pend[7] = 1'b1;
    for (int i = 0; i < 40; i++) begin tick(); if (to_irq[0]) irq_cnt++; end
    chk(irq_cnt == 1, "R9 single pulse", 32'(irq_cnt), 32'h1);
    chk(to_status[7] == 1'b1, "R2 held pending flags", 32'(to_status[7]), 32'h1);

    // R7 W1C
    tx_pend[7] = 1'b0;
    clr_we = 1'b1; clr_mask = 32'h0000_0080;
    tick();
    clr_we = 1'b0; clr_mask = '0;
    chk(to_status[7] == 1'b0, "R7 cpu clear", 32'(to_status[7]), 32'h0);

    // R4: deadline rewrite during scan, with write bursts stalling it
    toc_en[9] = 1'b1; tx_pend[9] = 1'b1;
    wr(9, 32'd0);
    for (int i = 20; i < 26; i++) begin wr(i, 32'hFFFF_FF00 + 32'(i)); tick(); end
    run(40);
    chk(to_status[9] == 1'b1, "R4 new deadline used", 32'(to_status[9]), 32'h1);

    // R7 set beats a clear held on the same bit
    toc_en[3] = 1'b1; tx_pend[3] = 1'b1;
    clr_we = 1'b1; clr_mask = 32'h0000_0008;
    seen = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (to_status[3]) seen++; end
    chk(seen > 0, "R7 set wins over clear", 32'(seen), 32'h1);
    tx_pend[3] = 1'b0;
    tick();
    clr_we = 1'b0; clr_mask = '0;
    run(3);
    chk(to_status[3] == 1'b0, "R7 cleared once idle", 32'(to_status[3]), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule